// File: doc/BRIEF.md
# Programmable Duty-Cycle Clock Divider

This block divides a fast input clock into a slower output clock whose low phase and high phase each last a separately programmed number of input cycles. The divider is clocked by the fast input clock. A small write-only register port holds the configuration: the two phase lengths, a phase offset, the level the output starts in, a bypass control, a sync-ignore control and a force-high control.

A chip-level sync input restarts the divider. Several instances sharing one sync line therefore come out of sync on the same input edge. Each instance then delays its first output edge by its own offset, which places the outputs at fixed, programmable phase relationships. An instance with sync-ignore set keeps running through a sync event and can hold its output high. In bypass the input clock is routed straight to the output.

Reset is synchronous and active low. Sync is assumed to be synchronous to the input clock.

Top module: `dcd_clock_divider`

## Requirements
- R1: While reset is asserted, the output is low. After reset every configuration field is zero, so the output starts low and toggles on every input rising edge (divide by two).
- R2: A write to address 0 puts the low-phase length L in data bits 7:4. The output then stays low for L+1 input cycles per period.
- R3: The same write to address 0 puts the high-phase length H in data bits 3:0. The output then stays high for H+1 input cycles per period.
- R4: With both lengths zero the output period is two input cycles, which is the smallest ratio. No phase is ever shorter than one input cycle.
- R5: Bit 4 of a write to address 1 selects the level the output takes when sync restarts it: 1 starts in the high phase, 0 starts in the low phase.
- R6: Bits 3:0 of a write to address 1 hold the offset O. Counting from the last rising edge at which sync is seen asserted, the output holds the start level for O+S+1 cycles, where S is the start phase's length field. After that it alternates normally.
- R7: While sync is asserted and obeyed, the output sits at the start level.
- R8: Bit 6 of address 1 set to 1 makes the divider ignore sync, so its waveform continues unchanged through a sync pulse.
- R9: Bit 5 of address 1 set to 1 holds the output high, but only while bit 6 is also 1. With bit 6 at 0, bit 5 has no effect.
- R10: Bit 7 of address 1 set to 1 routes the input clock directly to the output. This overrides force and the divider.
- R11: New phase lengths written while the divider runs do not shorten or stretch the phase in progress. They apply from the next phase boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock to be divided |
| rst_ni | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | Register select: 0 phase lengths, 1 mode and offset |
| wr_data_i | input | 8 | Register write data |
| sync_i | input | 1 | Chip-level restart, active high |
| div_o | output | 1 | Divided, bypassed or forced output clock |

## Verification
Every pairing of low and high lengths is tried after a sync restart with the low start level and zero offset. This separates the two length fields from each other and from their bit positions, and it confirms that a zero field still gives one cycle. A second sweep uses the high start level with every offset and with mixed lengths. This tells whether the offset is added to the start phase only, and whether the start phase takes the correct length field.

Directed patterns cover several cases:
- A long sync hold.
- A sync pulse while sync is ignored, which must not move the waveform.
- Force with and without sync-ignore.
- Bypass observed at both clock levels.
- A length change written in the middle of a phase. This shows whether new values take effect at the boundary or immediately.

// File: rtl/dcd_pkg.sv
// Package: shared types and register addresses for the duty-cycle divider.
// Assumes a one-bit register address space with two registers.
package dcd_pkg;

    // Register addresses on the write port
    localparam logic ADDR_LENGTHS = 1'b0;
    localparam logic ADDR_MODE    = 1'b1;

    // Mode flags held in the upper nibble of the mode register
    typedef struct packed {
        logic bypass;    // route input clock to output
        logic nosync;    // ignore the chip-level sync
        logic force_hi;  // hold output high (needs nosync)
        logic start_hi;  // level taken on sync restart
    } dcd_mode_t;

endpackage

// File: rtl/dcd_cfg_regs.sv
// Module: configuration registers of the divider.
// Holds the two phase-length fields, the offset field and the mode flags.
// Writes land on the rising edge where wr_en_i is high and are visible the
// following cycle. Assumes OFS_W <= 2*CNT_W - 4 so the offset fits below
// the mode flags in the mode register.
module dcd_cfg_regs
    import dcd_pkg::*;
#(
    parameter int unsigned CNT_W = 4,
    parameter int unsigned OFS_W = 4
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  wr_en_i,
    input  logic                  wr_addr_i,
    input  logic [2*CNT_W-1:0]    wr_data_i,
    output logic [CNT_W-1:0]      low_len_o,
    output logic [CNT_W-1:0]      high_len_o,
    output logic [OFS_W-1:0]      ofs_o,
    output dcd_mode_t             mode_o
);

    localparam int unsigned DATA_W = 2 * CNT_W;

    // Register write with synchronous active-low clear
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            low_len_o  <= '0;
            high_len_o <= '0;
            ofs_o      <= '0;
            mode_o     <= '0;
        end else if (wr_en_i) begin
            if (wr_addr_i == ADDR_LENGTHS) begin
                low_len_o  <= wr_data_i[DATA_W-1:CNT_W];
                high_len_o <= wr_data_i[CNT_W-1:0];
            end else begin
                mode_o.bypass   <= wr_data_i[DATA_W-1];
                mode_o.nosync   <= wr_data_i[DATA_W-2];
                mode_o.force_hi <= wr_data_i[DATA_W-3];
                mode_o.start_hi <= wr_data_i[DATA_W-4];
                ofs_o           <= wr_data_i[OFS_W-1:0];
            end
        end
    end

endmodule

// File: rtl/dcd_phase_engine.sv
// Module: phase counter and level register of the divider.
// A single down-counter times the phase in progress. When it reaches zero
// the level flips and the length of the new phase is loaded. A sync restart
// loads offset plus start-phase length, so the offset extends only the first
// phase. Lengths are read only when a phase is loaded, so a mid-phase change
// applies from the next boundary.
module dcd_phase_engine #(
    parameter int unsigned CNT_W = 4,
    parameter int unsigned OFS_W = 4,
    parameter int unsigned REM_W = ((CNT_W > OFS_W) ? CNT_W : OFS_W) + 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              restart_i,
    input  logic              start_hi_i,
    input  logic [CNT_W-1:0]  low_len_i,
    input  logic [CNT_W-1:0]  high_len_i,
    input  logic [OFS_W-1:0]  ofs_i,
    output logic              lvl_o,
    output logic [REM_W-1:0]  rem_o
);

    logic [REM_W-1:0] first_len;
    logic [REM_W-1:0] next_len;

    // Length of the first phase after restart: offset plus start-phase field
    always_comb begin
        first_len = REM_W'(ofs_i) + (start_hi_i ? REM_W'(high_len_i) : REM_W'(low_len_i));
    end

    // Length of the phase entered at a boundary (opposite of current level)
    always_comb begin
        next_len = lvl_o ? REM_W'(low_len_i) : REM_W'(high_len_i);
    end

    // Phase timer and output level
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            lvl_o <= 1'b0;
            rem_o <= '0;
        end else if (restart_i) begin
            lvl_o <= start_hi_i;
            rem_o <= first_len;
        end else if (rem_o == '0) begin
            lvl_o <= ~lvl_o;
            rem_o <= next_len;
        end else begin
            rem_o <= rem_o - 1'b1;
        end
    end

endmodule

// File: rtl/dcd_out_sel.sv
// Module: output selection of the divider.
// Bypass routes the input clock straight through. Otherwise force-high
// applies when sync is also ignored. Otherwise the divided level is used.
// Purely combinational; the bypass path carries the clock itself.
module dcd_out_sel
    import dcd_pkg::*;
(
    input  logic       clk_i,
    input  logic       lvl_i,
    input  dcd_mode_t  mode_i,
    output logic       div_o
);

    // Priority select: bypass, then force, then divided level
    always_comb begin
        if (mode_i.bypass) begin
            div_o = clk_i;
        end else if (mode_i.nosync && mode_i.force_hi) begin
            div_o = 1'b1;
        end else begin
            div_o = lvl_i;
        end
    end

endmodule

// File: rtl/dcd_clock_divider.sv
// Module: top of the programmable duty-cycle clock divider.
// Joins the configuration registers, the phase engine and the output select.
// Assumes sync_i is synchronous to clk_i and reset is synchronous, active low.
module dcd_clock_divider
    import dcd_pkg::*;
#(
    parameter int unsigned CNT_W = 4,
    parameter int unsigned OFS_W = 4
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               wr_en_i,
    input  logic               wr_addr_i,
    input  logic [2*CNT_W-1:0] wr_data_i,
    input  logic               sync_i,
    output logic               div_o
);

    localparam int unsigned REM_W = ((CNT_W > OFS_W) ? CNT_W : OFS_W) + 1;

    logic [CNT_W-1:0] low_len;
    logic [CNT_W-1:0] high_len;
    logic [OFS_W-1:0] ofs;
    dcd_mode_t        mode;
    logic             restart;
    logic             gen_lvl;
    logic [REM_W-1:0] rem_q;

    // Sync restarts the divider unless this instance ignores it
    always_comb begin
        restart = sync_i && !mode.nosync;
    end

    dcd_cfg_regs #(
        .CNT_W (CNT_W),
        .OFS_W (OFS_W)
    ) cfg_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .low_len_o  (low_len),
        .high_len_o (high_len),
        .ofs_o      (ofs),
        .mode_o     (mode)
    );

    dcd_phase_engine #(
        .CNT_W (CNT_W),
        .OFS_W (OFS_W),
        .REM_W (REM_W)
    ) eng_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .restart_i  (restart),
        .start_hi_i (mode.start_hi),
        .low_len_i  (low_len),
        .high_len_i (high_len),
        .ofs_i      (ofs),
        .lvl_o      (gen_lvl),
        .rem_o      (rem_q)
    );

    dcd_out_sel sel_i (
        .clk_i  (clk_i),
        .lvl_i  (gen_lvl),
        .mode_i (mode),
        .div_o  (div_o)
    );

endmodule

// File: rtl/dcd_clock_divider_chk.sv
// Module: assertion checker for the divider, bound to the top module.
// Observes the output, the mode flags and the phase engine state.
module dcd_clock_divider_chk #(
    parameter int unsigned REM_W = 5
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             sync_i,
    input logic             div_o,
    input logic             bypass_i,
    input logic             nosync_i,
    input logic             force_i,
    input logic             start_i,
    input logic             lvl_i,
    input logic [REM_W-1:0] rem_i
);

    // A cycle in reset leaves the output low on the next edge
    assert_reset_low_R1: assert property (@(posedge clk_i)
        !rst_ni |=> (div_o == 1'b0))
        else $error("R1: output not low after reset");

    // A running phase with time left keeps its level
    assert_phase_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!(sync_i && !nosync_i) && rem_i != '0) |=> $stable(lvl_i))
        else $error("R4: phase cut short");

    // An obeyed sync leaves the output at the start level
    assert_sync_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sync_i && !nosync_i) |=> (bypass_i || (nosync_i && force_i) || div_o == $past(start_i)))
        else $error("R7: output not at start level during sync");

    // An ignored sync neither restarts nor freezes the timer
    assert_sync_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sync_i && nosync_i) |=> (lvl_i == (($past(rem_i) == '0) ? !$past(lvl_i) : $past(lvl_i))))
        else $error("R8: ignored sync disturbed the divider");

    // Force with sync ignored and no bypass holds the output high
    assert_force_high_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (nosync_i && force_i && !bypass_i) |-> div_o)
        else $error("R9: forced output not high");

endmodule

bind dcd_clock_divider dcd_clock_divider_chk #(
    .REM_W (REM_W)
) chk_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sync_i   (sync_i),
    .div_o    (div_o),
    .bypass_i (mode.bypass),
    .nosync_i (mode.nosync),
    .force_i  (mode.force_hi),
    .start_i  (mode.start_hi),
    .lvl_i    (gen_lvl),
    .rem_i    (rem_q)
);

// File: tb/dcd_clock_divider_tb_top.sv
// Bench: sweeps phase lengths, start levels and offsets, and checks the
// output waveform cycle by cycle against an arithmetic model. Inputs change
// and outputs are sampled on falling edges.
module dcd_clock_divider_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = '0;
    logic       sync = 1'b0;
    logic       div;

    int checks = 0;
    int fails = 0;
    int cur_k = 0;
    bit done = 1'b0;

    dcd_clock_divider dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .sync_i    (sync),
        .div_o     (div)
    );

    // Free-running input clock
    always #(CLK_PERIOD/2) clk = ~clk;

    // Compare one value and count the check
    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d (k=%0d)", req, act, exp, cur_k);
        end
    endtask

    // Expected level k samples after the restart edge. The first phase lasts
    // l0 cycles at level s; then the opposite level for a cycles and s for b.
    function automatic int exp_lvl(int k, int s, int l0, int a, int b);
        int m;
        if (k < l0) return s;
        m = (k - l0) % (a + b);
        return (m < a) ? (1 - s) : s;
    endfunction

    // Register write, called at a falling edge; takes one cycle
    task automatic write_reg(input logic addr, input logic [7:0] data);
        wr_en = 1'b1;
        wr_addr = addr;
        wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
        cur_k++;
    endtask

    // Mode register write: bypass, nosync, force, start, offset
    task automatic set_mode(input bit byp, input bit ns, input bit frc, input bit st, input int ofs);
        write_reg(1'b1, {byp, ns, frc, st, 4'(ofs)});
    endtask

    // Two-cycle sync pulse; returns at the sample point k=0
    task automatic start_run();
        sync = 1'b1;
        @(negedge clk);
        @(negedge clk);
        sync = 1'b0;
        cur_k = 0;
    endtask

    // Check n successive samples against the model
    task automatic watch(input int n, input int s, input int l0, input int a, input int b, input string req);
        for (int i = 0; i < n; i++) begin
            check(req, int'(div), exp_lvl(cur_k, s, l0, a, b));
            @(negedge clk);
            cur_k++;
        end
    endtask

    // Watchdog: a hung run is a failed check
    initial begin
        #(CLK_PERIOD * MAX_CYCLES);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements): actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // R1: output low in reset, then divide by two from the low level
        repeat (3) @(negedge clk);
        check("R1 reset level", int'(div), 0);
        rst_n = 1'b1;
        cur_k = 0;
        watch(6, 0, 1, 1, 1, "R1 post-reset divide by two");

        // R2 R3 R4: every length pair, start low, offset zero
        for (int nl = 0; nl < 16; nl++) begin
            for (int nh = 0; nh < 16; nh++) begin
                write_reg(1'b0, {4'(nl), 4'(nh)});
                start_run();
                watch(nl + 1 + 2 * (nl + nh + 2), 0, nl + 1, nh + 1, nl + 1,
                      (nl == 0 && nh == 0) ? "R4 minimum ratio" : "R2/R3 phase lengths");
            end
        end

        // R5 R6: start high with every offset and mixed lengths
        for (int o = 0; o < 16; o++) begin
            int nl;
            int nh;
            nl = o % 5;
            nh = (o * 3) % 7;
            write_reg(1'b0, {4'(nl), 4'(nh)});
            set_mode(1'b0, 1'b0, 1'b0, 1'b1, o);
            start_run();
            watch(o + nh + 1 + 2 * (nl + nh + 2), 1, o + nh + 1, nl + 1, nh + 1, "R5/R6 start level and offset");
        end

        // R6: start low with an offset
        write_reg(1'b0, {4'd2, 4'd1});
        set_mode(1'b0, 1'b0, 1'b0, 1'b0, 5);
        start_run();
        watch(20, 0, 8, 2, 3, "R6 offset on low start");

        // R7: long sync hold keeps the start level
        set_mode(1'b0, 1'b0, 1'b0, 1'b1, 0);
        write_reg(1'b0, 8'h00);
        sync = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 20; i++) begin
            check("R7 held sync high start", int'(div), 1);
            @(negedge clk);
        end
        set_mode(1'b0, 1'b0, 1'b0, 1'b0, 0);
        @(negedge clk);
        for (int i = 0; i < 20; i++) begin
            check("R7 held sync low start", int'(div), 0);
            @(negedge clk);
        end
        sync = 1'b0;

        // R8: sync pulse ignored when nosync is set
        write_reg(1'b0, {4'd2, 4'd4});
        set_mode(1'b0, 1'b0, 1'b0, 1'b0, 0);
        start_run();
        watch(5, 0, 3, 5, 3, "R8 before nosync");
        set_mode(1'b0, 1'b1, 1'b0, 1'b0, 0);
        watch(3, 0, 3, 5, 3, "R8 nosync set");
        sync = 1'b1;
        watch(4, 0, 3, 5, 3, "R8 sync while ignored");
        sync = 1'b0;
        watch(12, 0, 3, 5, 3, "R8 after ignored sync");

        // R9: force high with nosync
        set_mode(1'b0, 1'b1, 1'b1, 1'b0, 0);
        for (int i = 0; i < 12; i++) begin
            check("R9 forced high", int'(div), 1);
            @(negedge clk);
        end
        // R9: force without nosync has no effect
        write_reg(1'b0, {4'd1, 4'd2});
        set_mode(1'b0, 1'b0, 1'b1, 1'b0, 0);
        start_run();
        watch(16, 0, 2, 3, 2, "R9 force ignored without nosync");

        // R10: bypass follows the clock, overriding force
        set_mode(1'b1, 1'b1, 1'b1, 1'b0, 0);
        for (int i = 0; i < 8; i++) begin
            @(posedge clk);
            #1;
            check("R10 bypass high half", int'(div), 1);
            @(negedge clk);
            #1;
            check("R10 bypass low half", int'(div), 0);
        end
        @(negedge clk);
        set_mode(1'b0, 1'b0, 1'b0, 1'b0, 0);

        // R11: mid-phase length change applies at the next boundary
        write_reg(1'b0, {4'd7, 4'd7});
        start_run();
        watch(3, 0, 8, 8, 8, "R11 before change");
        write_reg(1'b0, {4'd1, 4'd2});
        watch(20, 0, 8, 3, 2, "R11 after change");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule